// File: doc/BRIEF.md
# Cross-Domain Timer Register Update Bridge

This block sits between a processor bus and a small 8-bit timer. The timer can run from a slow, free-running oscillator clock that has no phase relation to the bus. Software writes three timer registers: the count, the compare value and a control byte, in which bit 0 enables counting. Every write lands first in a holding register on the bus side. When the timer runs from the oscillator, a busy flag is raised for that register, and a toggle request carries the value across. The timer side loads it and returns an acknowledge toggle, which drops the flag. A write that arrives while its flag is still up is refused and reported.

When the timer is switched to the bus clock, writes reach the timer registers directly on the next edge and no busy flag is raised. A status byte holds the clock-source select bit, an external-clock enable bit and the three busy flags. Reading the count returns the live timer value, carried across as a synchronized Gray-coded copy. Reading compare or control returns the holding register. Whenever the running count equals the compare value, the timer side sends a match event across, and that event sets a sticky interrupt flag.

Top module: `tmrXferBridge`

## Requirements
- R1: After reset, the status, compare readback, control readback and count all read 0. `irqFlag` and `wrErr` are 0, and `oscRun` is 1.
- R2: Register addresses are 0 count, 1 compare, 2 control, 3 status and 4 interrupt. In the status byte, bit 4 is external-clock enable and bit 3 is async select; both can be written. Bits 2, 1 and 0 are the count, compare and control busy flags and are read-only. Bits 7 to 5 always read 0.
- R3: With async select at 1, an accepted write to a timer register raises that register's busy bit on the cycle after the write. A busy bit never rises without such a write.
- R4: The busy bit is cleared by hardware once the timer side has loaded the held value. This happens within 80 bus cycles.
- R5: With async select at 0, a write loads the timer register directly and no busy bit is raised.
- R6: A write to a register whose busy bit is set is ignored. Its holding value is unchanged, and `wrErr` pulses on the next cycle.
- R7: Reading compare or control returns the holding register, including the value just written while the transfer is still pending.
- R8: Reading the count returns the live timer value. While counting without wrapping, successive reads never decrease.
- R9: The count advances by one on each timer clock while control bit 0 is 1, and holds while it is 0.
- R10: When the running count equals the compare value, `irqFlag` is set. It also reads as bit 0 at address 4. Writing 1 to bit 0 at address 4 clears it.
- R11: `oscRun` is the inverse of the external-clock enable bit.
- R12: With async select at 0, the timer clock is the bus clock. With async select at 1, it is `asyncClkIn`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| busClk | input | 1 | Bus clock |
| busRstN | input | 1 | Active-low asynchronous reset for both domains |
| asyncClkIn | input | 1 | Slow oscillator clock for the timer |
| addr | input | 3 | Register address |
| wrEn | input | 1 | Write strobe, one bus cycle |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for `addr` |
| wrErr | output | 1 | Pulses after a write refused because its register was busy |
| irqFlag | output | 1 | Sticky compare-match interrupt flag |
| oscRun | output | 1 | Crystal oscillator run enable |

## Verification
The assertions assume three things about the inputs. The clock-select bit is never changed while the counter is enabled or while a transfer is pending. The oscillator clock is several times slower than the bus clock. A match event is followed by at least a few oscillator periods before the next one. The stimulus keeps within these limits: it stops the counter and waits for all busy flags to clear before touching the select bit. It runs the oscillator at about one sixth of the bus rate. It places a single compare value that the count crosses only once in each window.

// File: rtl/tmrBridgePkg.sv
package tmrBridgePkg;
  localparam int REG_W    = 8;
  localparam int NUM_REGS = 3;
  localparam int ADDR_W   = 3;

  localparam int IDX_CNT = 0;
  localparam int IDX_CMP = 1;
  localparam int IDX_CTL = 2;

  localparam logic [ADDR_W-1:0] A_STAT = 3'd3;
  localparam logic [ADDR_W-1:0] A_IRQ  = 3'd4;

  localparam int ST_EXT   = 4;
  localparam int ST_ASYNC = 3;

  typedef struct packed {
    logic [NUM_REGS-1:0]             reqTgl;
    logic [NUM_REGS-1:0]             directLd;
    logic [REG_W-1:0]                directData;
    logic [NUM_REGS-1:0][REG_W-1:0]  hold;
  } tmrStrobe_t;

  function automatic logic [REG_W-1:0] gray2bin(input logic [REG_W-1:0] g);
    logic [REG_W-1:0] b;
    b[REG_W-1] = g[REG_W-1];
    for (int k = REG_W - 2; k >= 0; k--) b[k] = b[k+1] ^ g[k];
    return b;
  endfunction
endpackage

// File: rtl/tmrBridgeSync.sv
module tmrBridgeSync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stg <= '0;
    else       stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/tmrBridgeCore.sv
module tmrBridgeCore
  import tmrBridgePkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                tmrClk,
  input  logic                rstN,
  input  tmrStrobe_t          strb,
  output logic [NUM_REGS-1:0] ackTgl,
  output logic [REG_W-1:0]    cntGray,
  output logic                matchTgl
);
  logic [NUM_REGS-1:0] reqS, ackQ, reqEdge, load;
  logic [REG_W-1:0]    src  [NUM_REGS];
  logic [REG_W-1:0]    regQ [NUM_REGS];
  logic                matchNow, runEn;
  logic                unusedCtlBits;

  tmrBridgeSync #(.STAGES(SYNC_STAGES), .WIDTH(NUM_REGS)) uReqSync (
    .clk(tmrClk), .rstN(rstN), .d(strb.reqTgl), .q(reqS)
  );

  always_ff @(posedge tmrClk or negedge rstN) begin
    if (!rstN) ackQ <= '0;
    else       ackQ <= reqS;
  end

  assign reqEdge = reqS ^ ackQ;
  assign ackTgl  = ackQ;
  assign load    = reqEdge | strb.directLd;
  assign runEn   = regQ[IDX_CTL][0];
  assign unusedCtlBits = ^regQ[IDX_CTL][REG_W-1:1];

  for (genvar i = 0; i < NUM_REGS; i++) begin : gReg
    assign src[i] = strb.directLd[i] ? strb.directData : strb.hold[i];

    always_ff @(posedge tmrClk or negedge rstN) begin
      if (!rstN)                      regQ[i] <= '0;
      else if (load[i])               regQ[i] <= src[i];
      else if (i == IDX_CNT && runEn) regQ[i] <= regQ[i] + 1'b1;
    end

    // R4: a crossed request loads exactly the held value
    p_async_load_r4: assert property (@(posedge tmrClk) disable iff (!rstN)
      (reqEdge[i] && !strb.directLd[i]) |=> (regQ[i] == $past(strb.hold[i])));

    // R5: a direct strobe loads the bus data on the next edge
    p_sync_load_r5: assert property (@(posedge tmrClk) disable iff (!rstN)
      strb.directLd[i] |=> (regQ[i] == $past(strb.directData)));
  end

  assign matchNow = runEn && (regQ[IDX_CNT] == regQ[IDX_CMP]);

  always_ff @(posedge tmrClk or negedge rstN) begin
    if (!rstN) begin
      matchTgl <= 1'b0;
      cntGray  <= '0;
    end else begin
      if (matchNow) matchTgl <= ~matchTgl;
      cntGray <= regQ[IDX_CNT] ^ (regQ[IDX_CNT] >> 1);
    end
  end

  // R9: counting steps by one when enabled and not loaded
  p_count_step_r9: assert property (@(posedge tmrClk) disable iff (!rstN)
    (runEn && !load[IDX_CNT]) |=> (regQ[IDX_CNT] == REG_W'($past(regQ[IDX_CNT]) + 1'b1)));

  // R9: count holds when disabled and not loaded
  p_count_hold_r9: assert property (@(posedge tmrClk) disable iff (!rstN)
    (!runEn && !load[IDX_CNT]) |=> $stable(regQ[IDX_CNT]));
endmodule

// File: rtl/tmrBridgeCtrl.sv
module tmrBridgeCtrl
  import tmrBridgePkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                busClk,
  input  logic                busRstN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wrEn,
  input  logic [REG_W-1:0]    wrData,
  input  logic [NUM_REGS-1:0] ackTgl,
  input  logic [REG_W-1:0]    cntGray,
  input  logic                matchTgl,
  output tmrStrobe_t          strb,
  output logic                asyncSel,
  output logic [REG_W-1:0]    rdData,
  output logic                wrErr,
  output logic                irqFlag,
  output logic                oscRun
);
  logic [NUM_REGS-1:0] reqQ, ackS, busy, hit;
  logic [REG_W-1:0]    holdQ [NUM_REGS];
  logic [REG_W-1:0]    grayS, cntView, statByte;
  logic                extEnQ, asyncQ, irqQ, errQ;
  logic                matchS, matchPrev, matchEdge, irqClr;

  tmrBridgeSync #(.STAGES(SYNC_STAGES), .WIDTH(NUM_REGS)) uAckSync (
    .clk(busClk), .rstN(busRstN), .d(ackTgl), .q(ackS)
  );
  tmrBridgeSync #(.STAGES(SYNC_STAGES), .WIDTH(REG_W)) uCntSync (
    .clk(busClk), .rstN(busRstN), .d(cntGray), .q(grayS)
  );
  tmrBridgeSync #(.STAGES(SYNC_STAGES), .WIDTH(1)) uMatchSync (
    .clk(busClk), .rstN(busRstN), .d(matchTgl), .q(matchS)
  );

  assign busy = reqQ ^ ackS;

  for (genvar i = 0; i < NUM_REGS; i++) begin : gHit
    assign hit[i] = wrEn && (addr == ADDR_W'(i));
  end

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      reqQ <= '0;
      for (int i = 0; i < NUM_REGS; i++) holdQ[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (hit[i] && !busy[i]) begin
          holdQ[i] <= wrData;
          if (asyncQ) reqQ[i] <= ~reqQ[i];
        end
      end
    end
  end

  always_comb begin
    strb.reqTgl     = reqQ;
    strb.directLd   = hit & ~busy & {NUM_REGS{~asyncQ}};
    strb.directData = wrData;
    for (int i = 0; i < NUM_REGS; i++) strb.hold[i] = holdQ[i];
  end

  assign matchEdge = matchS ^ matchPrev;
  assign irqClr    = wrEn && (addr == A_IRQ) && wrData[0];

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      extEnQ    <= 1'b0;
      asyncQ    <= 1'b0;
      errQ      <= 1'b0;
      irqQ      <= 1'b0;
      matchPrev <= 1'b0;
    end else begin
      if (wrEn && addr == A_STAT) begin
        extEnQ <= wrData[ST_EXT];
        asyncQ <= wrData[ST_ASYNC];
      end
      errQ      <= |(hit & busy);
      matchPrev <= matchS;
      if (matchEdge)   irqQ <= 1'b1;
      else if (irqClr) irqQ <= 1'b0;
    end
  end

  assign cntView  = gray2bin(grayS);
  assign statByte = {3'b000, extEnQ, asyncQ, busy[IDX_CNT], busy[IDX_CMP], busy[IDX_CTL]};

  always_comb begin
    case (addr)
      ADDR_W'(IDX_CNT): rdData = cntView;
      ADDR_W'(IDX_CMP): rdData = holdQ[IDX_CMP];
      ADDR_W'(IDX_CTL): rdData = holdQ[IDX_CTL];
      A_STAT:           rdData = statByte;
      A_IRQ:            rdData = {{(REG_W-1){1'b0}}, irqQ};
      default:          rdData = '0;
    endcase
  end

  assign asyncSel = asyncQ;
  assign wrErr    = errQ;
  assign irqFlag  = irqQ;
  assign oscRun   = ~extEnQ;

  for (genvar i = 0; i < NUM_REGS; i++) begin : gChk
    // R3: a busy bit only rises after an accepted async write
    p_busy_src_r3: assert property (@(posedge busClk) disable iff (!busRstN)
      $rose(busy[i]) |-> $past(hit[i] && asyncQ));

    // R6: refused write flags an error and leaves the holding value
    p_refuse_r6: assert property (@(posedge busClk) disable iff (!busRstN)
      (hit[i] && busy[i]) |=> (wrErr && $stable(holdQ[i])));

    // R5: direct write in bus-clock mode leaves the flag low
    p_sync_nobusy_r5: assert property (@(posedge busClk) disable iff (!busRstN)
      (hit[i] && !busy[i] && !asyncQ) |=> !busy[i]);
  end

  // R10: write-one-to-clear drops the flag when no new match arrives
  p_irq_clear_r10: assert property (@(posedge busClk) disable iff (!busRstN)
    (irqClr && !matchEdge) |=> !irqFlag);
endmodule

// File: rtl/tmrXferBridge.sv
module tmrXferBridge
  import tmrBridgePkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              busClk,
  input  logic              busRstN,
  input  logic              asyncClkIn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  output logic              wrErr,
  output logic              irqFlag,
  output logic              oscRun
);
  tmrStrobe_t          strb;
  logic                asyncSel, tmrClk, matchTgl;
  logic [NUM_REGS-1:0] ackTgl;
  logic [REG_W-1:0]    cntGray;

  assign tmrClk = asyncSel ? asyncClkIn : busClk;

  tmrBridgeCtrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .busClk(busClk), .busRstN(busRstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .ackTgl(ackTgl), .cntGray(cntGray), .matchTgl(matchTgl), .strb(strb),
    .asyncSel(asyncSel), .rdData(rdData), .wrErr(wrErr), .irqFlag(irqFlag), .oscRun(oscRun)
  );

  tmrBridgeCore #(.SYNC_STAGES(SYNC_STAGES)) uCore (
    .tmrClk(tmrClk), .rstN(busRstN), .strb(strb),
    .ackTgl(ackTgl), .cntGray(cntGray), .matchTgl(matchTgl)
  );
endmodule

// File: tb/tmrXferBridge_test.sv
`timescale 1ns/1ps
module tmrXferBridge_test;
  logic       busClk = 0, busRstN = 0, asyncClkIn = 0;
  logic [2:0] addr = 0;
  logic       wrEn = 0;
  logic [7:0] wrData = 0;
  logic [7:0] rdData;
  logic       wrErr, irqFlag, oscRun;

  tmrXferBridge uut (
    .busClk(busClk), .busRstN(busRstN), .asyncClkIn(asyncClkIn), .addr(addr),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .wrErr(wrErr),
    .irqFlag(irqFlag), .oscRun(oscRun)
  );

  always #5    busClk     = ~busClk;
  always #30.5 asyncClkIn = ~asyncClkIn;

  int nCmp = 0, nBad = 0;
  bit done = 0;
  logic [7:0] mCmp = 0, mCtl = 0;
  logic       mExt = 0, mAsync = 0;
  logic [2:0] pend = 0;

  task automatic check(input string req, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model compared on every bus clock
  always @(negedge busClk) begin
    if (busRstN && !done) begin
      case (addr)
        3'd1: check("R7 compare readback", rdData, mCmp);
        3'd2: check("R7 control readback", rdData, mCtl);
        3'd3: check("R2 status high bits", rdData[7:3], {3'b000, mExt, mAsync});
        default: ;
      endcase
      check("R11 oscRun", oscRun, !mExt);
    end
  end

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    @(posedge busClk); #1;
    addr = a; wrData = d; wrEn = 1;
    @(posedge busClk); #1;
    wrEn = 0;
    if (a < 3 && !pend[a]) begin
      if (a == 1) mCmp = d;
      if (a == 2) mCtl = d;
      if (mAsync) pend[a] = 1'b1;
    end
    if (a == 3) begin
      mExt = d[4];
      mAsync = d[3];
    end
  endtask

  task automatic readReg(input logic [2:0] a, output logic [7:0] v);
    @(posedge busClk); #1;
    addr = a;
    @(negedge busClk);
    v = rdData;
  endtask

  task automatic waitIdle(input int idx);
    logic [7:0] v;
    bit cleared = 0;
    for (int k = 0; k < 80 && !cleared; k++) begin
      readReg(3'd3, v);
      if (!v[2-idx]) cleared = 1;
    end
    check("R4 busy cleared", cleared, 1);
    pend[idx] = 1'b0;
  endtask

  task automatic finishRun();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    #1_500_000;
    nBad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [7:0] v, a, b, prev;
    #25 busRstN = 1;

    // R1 reset state
    readReg(3'd3, v); check("R1 status", v, 0);
    readReg(3'd1, v); check("R1 compare", v, 0);
    readReg(3'd2, v); check("R1 control", v, 0);
    readReg(3'd0, v); check("R1 count", v, 0);
    check("R1 irqFlag", irqFlag, 0);
    check("R1 wrErr", wrErr, 0);
    check("R1 oscRun", oscRun, 1);

    // R5 bus-clock mode: direct loads, no busy
    busWrite(3'd1, 8'h20);
    readReg(3'd3, v); check("R5 no busy", v[2:0], 0);
    busWrite(3'd0, 8'h40);
    check("R5 no error", wrErr, 0);
    readReg(3'd3, v); check("R5 no busy", v[2:0], 0);
    repeat (6) @(posedge busClk);
    readReg(3'd0, v); check("R8 loaded count", v, 8'h40);

    // R12 bus-clock rate, R10 match in this mode
    busWrite(3'd0, 8'h00);
    busWrite(3'd2, 8'h01);
    repeat (10) @(posedge busClk);
    readReg(3'd0, a);
    repeat (49) @(posedge busClk);
    readReg(3'd0, b);
    check("R12 bus-clock rate", b - a, 50);
    repeat (20) @(posedge busClk);
    check("R10 irq set", irqFlag, 1);
    busWrite(3'd2, 8'h00);
    busWrite(3'd4, 8'h01);
    check("R10 irq cleared", irqFlag, 0);
    readReg(3'd0, a);
    repeat (30) @(posedge busClk);
    readReg(3'd0, b);
    check("R9 hold when disabled", b, a);

    // switch to oscillator clock, external clock first
    busWrite(3'd3, 8'h10);
    check("R11 oscRun off", oscRun, 0);
    busWrite(3'd3, 8'h18);
    repeat (20) @(posedge busClk);
    readReg(3'd3, v); check("R2 status", v, 8'h18);

    // R3 busy, R6 refused write, R7 readback while pending
    busWrite(3'd1, 8'h05);
    readReg(3'd3, v); check("R3 compare busy", v[2:0], 3'b010);
    busWrite(3'd1, 8'h99);
    check("R6 wrErr", wrErr, 1);
    readReg(3'd1, v); check("R6 value kept", v, 8'h05);
    waitIdle(1);
    @(posedge busClk); #1;
    check("R6 wrErr single", wrErr, 0);

    busWrite(3'd0, 8'h00);
    readReg(3'd3, v); check("R3 count busy", v[2:0], 3'b100);
    waitIdle(0);
    busWrite(3'd2, 8'h81);
    readReg(3'd3, v); check("R3 control busy", v[2:0], 3'b001);
    readReg(3'd2, v); check("R7 pending control", v, 8'h81);
    waitIdle(2);

    // R8 monotonic count, R12 oscillator rate
    readReg(3'd0, prev);
    for (int k = 0; k < 30; k++) begin
      repeat (9) @(posedge busClk);
      readReg(3'd0, v);
      check("R8 monotonic", (v >= prev) ? 1 : 0, 1);
      prev = v;
    end
    check("R8 count advanced", (prev > 8'h10) ? 1 : 0, 1);
    readReg(3'd0, a);
    repeat (59) @(posedge busClk);
    readReg(3'd0, b);
    check("R12 oscillator rate", ((b - a) >= 8 && (b - a) <= 11) ? 1 : 0, 1);
    check("R10 irq on async match", irqFlag, 1);
    readReg(3'd4, v); check("R10 irq readback", v, 8'h01);

    busWrite(3'd2, 8'h00);
    waitIdle(2);
    repeat (20) @(posedge busClk);
    readReg(3'd0, a);
    repeat (100) @(posedge busClk);
    readReg(3'd0, b);
    check("R9 async hold", b, a);
    busWrite(3'd4, 8'h01);
    check("R10 irq cleared async", irqFlag, 0);

    // R2 reserved and read-only bits
    busWrite(3'd3, 8'hE7);
    readReg(3'd3, v); check("R2 reserved bits", v, 8'h00);

    finishRun();
  end
endmodule